// File: doc/BRIEF.md
# Quad DAC Register and Power-Down Controller

This block is the digital control core of a four-channel, 12-bit voltage-output converter. It sits behind a serial command port that has already decoded a command into an opcode, a channel select, a broadcast flag and a 12-bit data field, delivered with a one-cycle valid strobe. Each channel is double-buffered. A staging (input) register can be loaded without disturbing the output. A DAC register holds the code that the converter string actually uses. Commands load either register, copy staged values into the DAC registers one channel at a time or all at once, put the device into one of three power-down modes, or wake it up.

For every channel the block drives the 12-bit straight-binary code and a one-hot termination select. The select is either the buffer enable, which also connects the string to the reference, or one of three powered-down choices: high impedance, a 1k pulldown or a 100k pulldown. After reset the device is asleep with the 100k pulldown selected and all codes at zero. It stays that way until a wake command arrives. Register contents survive power-down, so waking restores the previous outputs.

Top module: `qdac_ctrl`

## Requirements
- R1: Opcode 1 writes the data field into the input register of the selected channel only; the output code of every channel is unchanged by it.
- R2: Opcode 2 writes the data field into both the input and DAC register of the selected channel; the code output shows the new value in the cycle after the strobe.
- R3: After synchronous reset all input and DAC registers are zero, the device is asleep, the power mode code is 2 and every channel selects the 100k pulldown.
- R4: After reset no channel asserts buffer enable until a command with opcode 12 (wake) has been accepted.
- R5: Opcodes 8, 9 and 10 put the device to sleep in mode 0 (high impedance), mode 1 (1k pulldown) and mode 2 (100k pulldown) respectively; buffer enable drops on all channels.
- R6: Input and DAC registers keep their values through power-down, may still be written while asleep, and after wake the codes are the DAC register values held before.
- R7: Opcode 3 copies the selected channel's input register into its DAC register; with the broadcast flag set, opcodes 1, 2 and 3 act on all four channels.
- R8: Opcode 4 copies all four input registers into their DAC registers in the same clock cycle, regardless of the channel select.
- R9: For each channel exactly one of buffer enable, high impedance, 1k pulldown and 100k pulldown is asserted at all times.
- R10: The mode output reports 0, 1 or 2 for the current sleep mode and 3 while awake; the awake output is high only while awake.
- R11: Opcodes other than 1, 2, 3, 4, 8, 9, 10 and 12, and any command without the valid strobe, change no register or output.
- R12: Channel n's straight-binary code appears on code_o bits [12n+11:12n], covering 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_ch | input | 2 | Channel select |
| cmd_all | input | 1 | Broadcast flag for opcodes 1 to 3 |
| cmd_data | input | 12 | Data field |
| code_o | output | 48 | Packed per-channel DAC codes |
| buf_en_o | output | 4 | Per-channel buffer enable / string connect |
| hiz_o | output | 4 | Per-channel high-impedance select |
| pd1k_o | output | 4 | Per-channel 1k pulldown select |
| pd100k_o | output | 4 | Per-channel 100k pulldown select |
| mode_o | output | 2 | Power mode code (3 while awake) |
| awake_o | output | 1 | High while outputs are driven |

## Verification
On every cycle the assertions check that the termination selects are one-hot, that a DAC register does not move without a load or copy, that a staging-only write leaves the code alone, that a copy lands the staged value, that sleep and reset states hold, and that buffers stay off while no wake has been seen. Which code value each broadcast, load-all or wake-after-sleep sequence must produce, and whether undefined opcodes leave everything intact, can only be shown by the bench's reference model over its scenarios.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [3:0] {
        OP_LOAD_IN  = 4'h1,
        OP_LOAD_DAC = 4'h2,
        OP_XFER     = 4'h3,
        OP_LOAD_ALL = 4'h4,
        OP_PD_HIZ   = 4'h8,
        OP_PD_1K    = 4'h9,
        OP_PD_100K  = 4'hA,
        OP_WAKE     = 4'hC
    } qdac_op_e;

    typedef enum logic [1:0] {
        PM_HIZ   = 2'd0,
        PM_1K    = 2'd1,
        PM_100K  = 2'd2,
        PM_AWAKE = 2'd3
    } qdac_pm_e;

    typedef struct packed {
        logic drive;
        logic hiz;
        logic r1k;
        logic r100k;
    } qdac_term_t;

    function automatic qdac_term_t term_of(input logic awake, input qdac_pm_e pm);
        qdac_term_t t;
        t = '0;
        if (awake) begin
            t.drive = 1'b1;
        end else begin
            case (pm)
                PM_HIZ:  t.hiz   = 1'b1;
                PM_1K:   t.r1k   = 1'b1;
                default: t.r100k = 1'b1;
            endcase
        end
        return t;
    endfunction

    function automatic qdac_pm_e pm_of_op(input logic [3:0] op);
        case (op)
            OP_PD_HIZ: return PM_HIZ;
            OP_PD_1K:  return PM_1K;
            default:   return PM_100K;
        endcase
    endfunction

endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [CHW-1:0] cmd_ch,
    input  logic           cmd_all,
    output logic [NCH-1:0] wr_in,
    output logic [NCH-1:0] wr_dac,
    output logic [NCH-1:0] xfer,
    output logic           pd_req,
    output qdac_pm_e       pd_mode,
    output logic           wake_req
);
    logic [NCH-1:0] target;

    always_comb begin
        target = '0;
        if (cmd_all) target = '1;
        else         target[cmd_ch] = 1'b1;
    end

    always_comb begin
        wr_in    = '0;
        wr_dac   = '0;
        xfer     = '0;
        pd_req   = 1'b0;
        wake_req = 1'b0;
        pd_mode  = pm_of_op(cmd_op);
        if (cmd_valid) begin
            case (cmd_op)
                OP_LOAD_IN:  wr_in = target;
                OP_LOAD_DAC: begin
                    wr_in  = target;
                    wr_dac = target;
                end
                OP_XFER:     xfer = target;
                OP_LOAD_ALL: xfer = '1;
                OP_PD_HIZ, OP_PD_1K, OP_PD_100K: pd_req = 1'b1;
                OP_WAKE:     wake_req = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_in,
    input  logic          wr_dac,
    input  logic          xfer,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] code
);
    logic [DW-1:0] in_q;
    logic [DW-1:0] dac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            if (wr_in)       in_q  <= data;
            if (wr_dac)      dac_q <= data;
            else if (xfer)   dac_q <= in_q;
        end
    end

    assign code = dac_q;

    // R1: staging-only write leaves the output code alone
    p_input_only_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_in && !wr_dac && !xfer) |=> $stable(code));

    // R7: a copy lands the previously staged value
    p_xfer_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (xfer && !wr_dac) |=> (code == $past(in_q)));

    // R6: without a load or copy the DAC register is retained
    p_retain_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_dac && !xfer) |=> $stable(code));

    // R3: zero scale right after reset
    p_reset_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code == '0 && in_q == '0));
endmodule

// File: rtl/qdac_power.sv
module qdac_power
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pd_req,
    input  qdac_pm_e       pd_mode,
    input  logic           wake_req,
    output logic [NCH-1:0] buf_en,
    output logic [NCH-1:0] hiz,
    output logic [NCH-1:0] pd1k,
    output logic [NCH-1:0] pd100k,
    output logic [1:0]     mode,
    output logic           awake
);
    logic       awake_q;
    qdac_pm_e   pm_q;
    qdac_term_t term;

    always_ff @(posedge clk) begin
        if (rst) begin
            awake_q <= 1'b0;
            pm_q    <= PM_100K;
        end else if (pd_req) begin
            awake_q <= 1'b0;
            pm_q    <= pd_mode;
        end else if (wake_req) begin
            awake_q <= 1'b1;
        end
    end

    assign term  = term_of(awake_q, pm_q);
    assign awake = awake_q;
    assign mode  = awake_q ? PM_AWAKE : pm_q;

    for (genvar c = 0; c < NCH; c++) begin : g_term
        assign buf_en[c] = term.drive;
        assign hiz[c]    = term.hiz;
        assign pd1k[c]   = term.r1k;
        assign pd100k[c] = term.r100k;

        // R9: exactly one termination choice per channel
        p_term_onehot_r9: assert property (@(posedge clk) disable iff (rst)
            $countones({buf_en[c], hiz[c], pd1k[c], pd100k[c]}) == 1);
    end

    // R5: a sleep command turns the buffers off on the next cycle
    p_sleep_off_r5: assert property (@(posedge clk) disable iff (rst)
        pd_req |=> (buf_en == '0 && mode == $past(pd_mode)));

    // R3: reset state is asleep with the 100k path
    p_reset_sleep_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!awake && pd100k == '1 && mode == 2'd2));

    // R10: awake flag and mode code agree
    p_status_r10: assert property (@(posedge clk) disable iff (rst)
        awake == (mode == 2'd3));
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [CHW-1:0]    cmd_ch,
    input  logic              cmd_all,
    input  logic [DW-1:0]     cmd_data,
    output logic [NCH*DW-1:0] code_o,
    output logic [NCH-1:0]    buf_en_o,
    output logic [NCH-1:0]    hiz_o,
    output logic [NCH-1:0]    pd1k_o,
    output logic [NCH-1:0]    pd100k_o,
    output logic [1:0]        mode_o,
    output logic              awake_o
);
    logic [NCH-1:0] wr_in, wr_dac, xfer;
    logic           pd_req, wake_req;
    qdac_pm_e       pd_mode;

    qdac_cmd_decode #(.NCH(NCH)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ch    (cmd_ch),
        .cmd_all   (cmd_all),
        .wr_in     (wr_in),
        .wr_dac    (wr_dac),
        .xfer      (xfer),
        .pd_req    (pd_req),
        .pd_mode   (pd_mode),
        .wake_req  (wake_req)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        qdac_chan #(.DW(DW)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .wr_in  (wr_in[c]),
            .wr_dac (wr_dac[c]),
            .xfer   (xfer[c]),
            .data   (cmd_data),
            .code   (code_o[c*DW +: DW])
        );
    end

    qdac_power #(.NCH(NCH)) u_pwr (
        .clk      (clk),
        .rst      (rst),
        .pd_req   (pd_req),
        .pd_mode  (pd_mode),
        .wake_req (wake_req),
        .buf_en   (buf_en_o),
        .hiz      (hiz_o),
        .pd1k     (pd1k_o),
        .pd100k   (pd100k_o),
        .mode     (mode_o),
        .awake    (awake_o)
    );

    // R4: buffers stay off while asleep and no wake arrives
    p_no_drive_asleep_r4: assert property (@(posedge clk) disable iff (rst)
        (!awake_o && !(cmd_valid && cmd_op == OP_WAKE)) |=> (buf_en_o == '0));

    // R11: an idle bus changes no code
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(code_o) && $stable(mode_o)));
endmodule

// File: tb/qdac_ctrl_test.sv
module qdac_ctrl_test;
    localparam int NCH = 4;
    localparam int DW  = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [1:0]        cmd_ch = '0;
    logic              cmd_all = 1'b0;
    logic [DW-1:0]     cmd_data = '0;
    logic [NCH*DW-1:0] code_o;
    logic [NCH-1:0]    buf_en_o, hiz_o, pd1k_o, pd100k_o;
    logic [1:0]        mode_o;
    logic              awake_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_in  [NCH];
    int m_dac [NCH];
    int m_awake;
    int m_mode;

    always #5 clk = ~clk;

    qdac_ctrl #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ch(cmd_ch), .cmd_all(cmd_all), .cmd_data(cmd_data),
        .code_o(code_o), .buf_en_o(buf_en_o), .hiz_o(hiz_o),
        .pd1k_o(pd1k_o), .pd100k_o(pd100k_o), .mode_o(mode_o), .awake_o(awake_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin m_in[c] = 0; m_dac[c] = 0; end
            m_awake = 0;
            m_mode  = 2;
        end else if (cmd_valid) begin
            int tmp [NCH];
            for (int c = 0; c < NCH; c++) tmp[c] = m_in[c];
            for (int c = 0; c < NCH; c++) begin
                bit hit;
                hit = cmd_all || (cmd_ch == c);
                case (cmd_op)
                    4'h1: if (hit) m_in[c] = cmd_data;
                    4'h2: if (hit) begin m_in[c] = cmd_data; m_dac[c] = cmd_data; end
                    4'h3: if (hit) m_dac[c] = tmp[c];
                    4'h4: m_dac[c] = tmp[c];
                    default: ;
                endcase
            end
            case (cmd_op)
                4'h8: begin m_awake = 0; m_mode = 0; end
                4'h9: begin m_awake = 0; m_mode = 1; end
                4'hA: begin m_awake = 0; m_mode = 2; end
                4'hC: m_awake = 1;
                default: ;
            endcase
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                check("R12 code", code_o[c*DW +: DW], m_dac[c]);
                check("R9 drive", buf_en_o[c], m_awake);
                check("R9 hiz",   hiz_o[c],   !m_awake && m_mode == 0);
                check("R9 1k",    pd1k_o[c],  !m_awake && m_mode == 1);
                check("R9 100k",  pd100k_o[c],!m_awake && m_mode == 2);
            end
            check("R10 mode",  mode_o, m_awake ? 3 : m_mode);
            check("R10 awake", awake_o, m_awake);
        end
    end

    task automatic send(input logic [3:0] op, input int ch, input bit all, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch[1:0]; cmd_all = all; cmd_data = data[DW-1:0];
        @(negedge clk);
        cmd_valid = 1'b0; cmd_all = 1'b0;
    endtask

    function automatic int code_of(input int c);
        return int'(code_o[c*DW +: DW]);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        for (int c = 0; c < NCH; c++) check("R3 code zero", code_of(c), 0);
        check("R3 pd100k", pd100k_o, 4'hF);
        check("R3 mode", mode_o, 2);

        // R1 staging write only
        send(4'h1, 1, 0, 'hABC);
        #1 check("R1 code unchanged", code_of(1), 0);

        // R2 direct load while asleep, R4 no drive yet
        send(4'h2, 2, 0, 'h123);
        #1 check("R2 code", code_of(2), 'h123);
        check("R4 no drive before wake", buf_en_o, 0);
        repeat (3) @(negedge clk);
        check("R4 still off", buf_en_o, 0);

        send(4'hC, 0, 0, 0);
        #1 check("R4 driving after wake", buf_en_o, 4'hF);

        // R5 each sleep mode
        send(4'h8, 0, 0, 0);
        #1 check("R5 hiz", hiz_o, 4'hF);
        send(4'h9, 0, 0, 0);
        #1 check("R5 1k", pd1k_o, 4'hF);
        send(4'hA, 0, 0, 0);
        #1 check("R5 100k", pd100k_o, 4'hF);

        // R6 write while asleep, then wake restores
        send(4'h2, 0, 0, 'h7FF);
        send(4'hC, 0, 0, 0);
        #1 check("R6 ch2 retained", code_of(2), 'h123);
        check("R6 ch0 written asleep", code_of(0), 'h7FF);

        // R7 single copy and broadcast
        send(4'h3, 1, 0, 0);
        #1 check("R7 copy ch1", code_of(1), 'hABC);
        send(4'h1, 0, 1, 'h555);
        send(4'h2, 3, 1, 'h0F0);
        #1 check("R7 broadcast direct", code_of(0), 'h0F0);

        // R8 load all
        for (int c = 0; c < NCH; c++) send(4'h1, c, 0, 'h100 * (c + 1));
        send(4'h4, 2, 0, 0);
        #1 for (int c = 0; c < NCH; c++) check("R8 load all", code_of(c), 'h100 * (c + 1));

        // R11 undefined opcode and missing strobe
        send(4'h5, 0, 1, 'hFFF);
        send(4'hF, 0, 1, 'hFFF);
        @(negedge clk);
        cmd_op = 4'h2; cmd_all = 1'b1; cmd_data = 'hEEE;
        @(negedge clk);
        cmd_all = 1'b0;
        send(4'h4, 0, 0, 0);
        #1 check("R11 ignored", code_of(3), 'h400);

        // R12 full scale
        send(4'h2, 3, 0, 'hFFF);
        #1 check("R12 full scale", code_o[47:36], 'hFFF);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule